// File: doc/BRIEF.md
# Credit-Budgeted Non-Preemptive Task Arbiter

This block sits beside one processor and decides which of a fixed set of actor slots (tasks) may run next. A host writes a firing budget for each slot. At the start of every budget period each slot's live counter is filled from that stored budget. The arbiter then walks the slots in a circular order. When it finds a slot that is ready and still has budget left, it hands the processor to that slot. It then waits, without preempting, until the running actor reports completion, and charges that slot one firing.

Slots that are not ready are passed over, so processor time is never held back for them. A period ends either when the external period timer ticks or, earlier, when every live counter has reached zero and nothing is running. Budgets written by the host land in a shadow store and only reach the live counters at the next refill. An idle-cycle counter supports utilization measurement. A completion pulse that arrives while nothing is granted is dropped and raises a sticky flag.

Top module: `credit_arbiter`

## Requirements
- R1: On each refill every slot's live counter takes the value held in that slot's shadow store. `refill_o` pulses high for the one cycle after the refill edge.
- R2: A grant is issued only to a slot whose ready input is high and whose live counter is above zero in the deciding cycle. `grant_valid_o` rises one cycle after that edge, and `grant_slot_o` carries the slot number.
- R3: Each `fire_done_i` pulse taken while a grant is outstanding lowers the granted slot's live counter by one. A slot whose counter is zero is not granted again until the next refill.
- R4: The scan pointer advances one slot in every cycle in which it examines a slot, whether or not that slot is granted. It wraps from slot N_ACT-1 to slot 0. After reset it starts at slot 0.
- R5: A slot that is not ready when the pointer reaches it is skipped at once, and the scan moves on in the next cycle.
- R6: A `period_tick_i` pulse causes a refill in the first cycle with no grant outstanding. A tick that arrives during a grant is remembered until the grant completes.
- R7: With no grant outstanding and all live counters at zero, a refill happens without a tick, and `early_close_o` pulses together with `refill_o`.
- R8: While a grant is outstanding, `grant_valid_o` stays high and `grant_slot_o` stays unchanged until `fire_done_i` is seen. `grant_valid_o` falls one cycle after the done edge.
- R9: A budget write (`cred_wr_i` with slot and value) changes only the shadow store. A write at the same edge as a refill is not seen by that refill.
- R10: `idle_cycles_o` increases by one for each clock edge at which no grant was outstanding and none was issued, and it saturates at its maximum.
- R11: `fire_done_i` with no grant outstanding changes no counter and no grant state, and sets `stray_done_o`, which stays high until reset.
- R12: While and after reset the outputs `grant_valid_o`, `refill_o`, `early_close_o`, `stray_done_o` and `idle_cycles_o` are zero, and all shadow and live budgets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_ready_i | input | N_ACT | Per-slot ready flags |
| cred_wr_i | input | 1 | Budget write strobe |
| cred_slot_i | input | SLOT_W | Slot addressed by the budget write |
| cred_val_i | input | CRED_W | Budget value (firings per period) |
| fire_done_i | input | 1 | Completion pulse from the running actor |
| period_tick_i | input | 1 | Budget period expiry |
| grant_valid_o | output | 1 | A grant is outstanding |
| grant_slot_o | output | SLOT_W | Slot holding the processor |
| refill_o | output | 1 | Refill took place at the previous edge |
| early_close_o | output | 1 | That refill closed the period early |
| idle_cycles_o | output | IDLE_W | Saturating idle-cycle count |
| stray_done_o | output | 1 | Sticky: completion seen with no grant |

## Verification
Every output is registered. A decision, refill, charge or flag taken at one rising edge therefore shows on the ports one cycle later, and a tick raised during a grant shows as `refill_o` one cycle after the edge that also lowers `grant_valid_o`'s successor edge. The bench drives inputs and compares at the falling edge. At each rising edge a behavioural model applies the same inputs to its own view of the counters, pointer and pending tick. The model's result is compared at the next falling edge, which is exactly when the design's registers have taken the same step. Stimulus covers shadow writes during a period, all-not-ready stretches, ticks during grants, exhausted budgets that close a period early, and stray completions.

// File: rtl/cba_pkg.sv
package cba_pkg;
  // Scheduler phase: scanning for an eligible slot or holding a grant.
  typedef enum logic {
    PH_SCAN = 1'b0,
    PH_HOLD = 1'b1
  } sched_ph_e;
endpackage

// File: rtl/cba_credit_bank.sv
module cba_credit_bank #(
  parameter int N_ACT  = 4,
  parameter int CRED_W = 8,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [CRED_W-1:0] wr_val,
  input  logic              refill,
  input  logic              charge,
  input  logic [SLOT_W-1:0] charge_slot,
  output logic [N_ACT-1:0]  has_cred,
  output logic              all_empty
);

  for (genvar g = 0; g < N_ACT; g++) begin : g_slot
    logic [CRED_W-1:0] shadow_q, shadow_d;
    logic [CRED_W-1:0] live_q, live_d;

    always_comb begin
      shadow_d = shadow_q;
      if (wr_en && (wr_slot == SLOT_W'(g))) shadow_d = wr_val;
    end

    always_comb begin
      live_d = live_q;
      if (refill)                                           live_d = shadow_q;
      else if (charge && (charge_slot == SLOT_W'(g)))       live_d = live_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        shadow_q <= shadow_d;
        live_q   <= live_d;
      end
    end

    assign has_cred[g] = |live_q;
  end

  assign all_empty = ~|has_cred;

  // A charge must never hit a slot that is already out of budget.
  assert_charge_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    charge |-> has_cred[charge_slot]);

  // A charge and a refill never coincide (refill waits for the grant to end).
  assert_charge_vs_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    charge |-> !refill);

endmodule

// File: rtl/cba_period_ctrl.sv
module cba_period_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic all_empty,
  input  logic busy,
  output logic refill,
  output logic refill_q,
  output logic early_q
);

  logic pend_q, pend_d;
  logic early_d;

  always_comb begin
    refill  = !busy && (tick || pend_q || all_empty);
    early_d = refill && !tick && !pend_q;
    pend_d  = pend_q;
    if (refill)    pend_d = 1'b0;
    else if (tick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      refill_q <= 1'b0;
      early_q  <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      refill_q <= refill;
      early_q  <= early_d;
    end
  end

  // A remembered tick is served as soon as the grant ends.
  assert_pending_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy) |=> refill_q);

  // An early close is always reported as a refill too.
  assert_early_is_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    early_q |-> refill_q);

endmodule

// File: rtl/cba_scheduler.sv
module cba_scheduler
  import cba_pkg::*;
#(
  parameter int N_ACT  = 4,
  parameter int SLOT_W = 2,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ACT-1:0]  ready,
  input  logic [N_ACT-1:0]  has_cred,
  input  logic              refill,
  input  logic              done,
  output logic              busy,
  output logic [SLOT_W-1:0] grant_slot,
  output logic              charge,
  output logic [SLOT_W-1:0] charge_slot,
  output logic [IDLE_W-1:0] idle_cnt,
  output logic              stray
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_ACT - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = '1;

  sched_ph_e         ph_q, ph_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOT_W-1:0] gslot_q, gslot_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              stray_q, stray_d;
  logic              scan, pick;

  always_comb begin
    scan    = (ph_q == PH_SCAN) && !refill;
    pick    = scan && ready[ptr_q] && has_cred[ptr_q];

    ph_d    = ph_q;
    if ((ph_q == PH_HOLD) && done) ph_d = PH_SCAN;
    else if (pick)                 ph_d = PH_HOLD;

    ptr_d   = ptr_q;
    if (scan) ptr_d = (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;

    gslot_d = pick ? ptr_q : gslot_q;

    idle_d  = idle_q;
    if ((ph_q == PH_SCAN) && !pick && (idle_q != IDLE_MAX)) idle_d = idle_q + 1'b1;

    stray_d = stray_q | (done && (ph_q == PH_SCAN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_SCAN;
      ptr_q   <= '0;
      gslot_q <= '0;
      idle_q  <= '0;
      stray_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      ptr_q   <= ptr_d;
      gslot_q <= gslot_d;
      idle_q  <= idle_d;
      stray_q <= stray_d;
    end
  end

  assign busy        = (ph_q == PH_HOLD);
  assign grant_slot  = gslot_q;
  assign charge      = busy && done;
  assign charge_slot = gslot_q;
  assign idle_cnt    = idle_q;
  assign stray       = stray_q;

  // Non-preemptive hold: grant and slot persist until completion.
  assert_hold_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(grant_slot)));

  // Stray-completion flag is sticky.
  assert_stray_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stray |=> stray);

  // Idle count never goes down.
  assert_idle_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idle_cnt >= $past(idle_cnt)));

endmodule

// File: rtl/credit_arbiter.sv
module credit_arbiter #(
  parameter int N_ACT  = 4,
  parameter int CRED_W = 8,
  parameter int IDLE_W = 16,
  localparam int SLOT_W = (N_ACT > 1) ? $clog2(N_ACT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ACT-1:0]  act_ready_i,
  input  logic              cred_wr_i,
  input  logic [SLOT_W-1:0] cred_slot_i,
  input  logic [CRED_W-1:0] cred_val_i,
  input  logic              fire_done_i,
  input  logic              period_tick_i,
  output logic              grant_valid_o,
  output logic [SLOT_W-1:0] grant_slot_o,
  output logic              refill_o,
  output logic              early_close_o,
  output logic [IDLE_W-1:0] idle_cycles_o,
  output logic              stray_done_o
);

  logic [N_ACT-1:0]  has_cred;
  logic              all_empty;
  logic              refill;
  logic              busy;
  logic              charge;
  logic [SLOT_W-1:0] charge_slot;

  cba_credit_bank #(.N_ACT(N_ACT), .CRED_W(CRED_W), .SLOT_W(SLOT_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cred_wr_i),
    .wr_slot     (cred_slot_i),
    .wr_val      (cred_val_i),
    .refill      (refill),
    .charge      (charge),
    .charge_slot (charge_slot),
    .has_cred    (has_cred),
    .all_empty   (all_empty)
  );

  cba_period_ctrl u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (period_tick_i),
    .all_empty (all_empty),
    .busy      (busy),
    .refill    (refill),
    .refill_q  (refill_o),
    .early_q   (early_close_o)
  );

  cba_scheduler #(.N_ACT(N_ACT), .SLOT_W(SLOT_W), .IDLE_W(IDLE_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (act_ready_i),
    .has_cred    (has_cred),
    .refill      (refill),
    .done        (fire_done_i),
    .busy        (busy),
    .grant_slot  (grant_slot_o),
    .charge      (charge),
    .charge_slot (charge_slot),
    .idle_cnt    (idle_cycles_o),
    .stray       (stray_done_o)
  );

  assign grant_valid_o = busy;

  // A held grant always belongs to a slot that still has budget.
  assert_grant_has_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> has_cred[grant_slot_o]);

  // No refill while the processor is held.
  assert_no_refill_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> !refill);

endmodule

// File: tb/credit_arbiter_bench.sv
`timescale 1ns/1ps
module credit_arbiter_bench;
  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int IDW = 16;
  localparam int SW  = 2;
  localparam int IDLE_SAT = (1 << IDW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ready;
  logic          wr;
  logic [SW-1:0] wslot;
  logic [CW-1:0] wval;
  logic          done;
  logic          tick;
  logic          gv;
  logic [SW-1:0] gslot;
  logic          rf, early;
  logic [IDW-1:0] idle;
  logic          stray;

  always #2.5 clk = ~clk;

  credit_arbiter #(.N_ACT(N), .CRED_W(CW), .IDLE_W(IDW)) u_credit_arbiter (
    .clk(clk), .rst_n(rst_n), .act_ready_i(ready), .cred_wr_i(wr),
    .cred_slot_i(wslot), .cred_val_i(wval), .fire_done_i(done),
    .period_tick_i(tick), .grant_valid_o(gv), .grant_slot_o(gslot),
    .refill_o(rf), .early_close_o(early), .idle_cycles_o(idle),
    .stray_done_o(stray)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Behavioural reference model
  int  m_shadow[N];
  int  m_live[N];
  int  m_ptr, m_gslot, m_idle;
  bit  m_busy, m_pend, m_rf, m_early, m_stray;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_shadow[i]) begin m_shadow[i] = 0; m_live[i] = 0; end
      m_ptr = 0; m_gslot = 0; m_idle = 0;
      m_busy = 0; m_pend = 0; m_rf = 0; m_early = 0; m_stray = 0;
    end else begin
      bit empty, rl, was_busy;
      empty = 1;
      foreach (m_live[i]) if (m_live[i] != 0) empty = 0;
      was_busy = m_busy;
      rl = !was_busy && (tick || m_pend || empty);
      m_rf = rl;
      m_early = rl && !tick && !m_pend;
      if (rl) m_pend = 0; else if (tick) m_pend = 1;
      if (was_busy && done) begin
        m_live[m_gslot] = m_live[m_gslot] - 1;
        m_busy = 0;
      end else if (!was_busy && done) begin
        m_stray = 1;
      end
      if (rl) begin
        foreach (m_live[i]) m_live[i] = m_shadow[i];
        if (m_idle < IDLE_SAT) m_idle++;
      end else if (!was_busy) begin
        if (ready[m_ptr] && m_live[m_ptr] > 0) begin
          m_busy = 1; m_gslot = m_ptr;
        end else if (m_idle < IDLE_SAT) begin
          m_idle++;
        end
        m_ptr = (m_ptr + 1) % N;
      end
      if (wr) m_shadow[wslot] = int'(wval);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(gv == m_busy, "R2 R3 R5 R8 grant_valid", int'(gv), int'(m_busy));
    if (m_busy) chk(int'(gslot) == m_gslot, "R4 R8 grant_slot", int'(gslot), m_gslot);
    chk(rf == m_rf, "R1 R6 R9 refill", int'(rf), int'(m_rf));
    chk(early == m_early, "R7 early_close", int'(early), int'(m_early));
    chk(int'(idle) == m_idle, "R10 idle_cycles", int'(idle), m_idle);
    chk(stray == m_stray, "R11 stray_done", int'(stray), int'(m_stray));
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(input int ready_mode, input int done_pct, input bit do_tick,
                      input bit stray_pulse);
    @(negedge clk);
    compare_all();
    wr = 1'b0;
    tick = do_tick;
    case (ready_mode)
      0: ready = '0;
      1: ready = '1;
      default: ready = N'($urandom);
    endcase
    if (stray_pulse) done = !m_busy;
    else done = m_busy && (($urandom % 100) < done_pct);
  endtask

  task automatic write_cred(input int s, input int v);
    @(negedge clk);
    compare_all();
    wr = 1'b1; wslot = SW'(s); wval = CW'(v);
    tick = 1'b0;
    done = m_busy;
  endtask

  initial begin
    rst_n = 1'b0; ready = '0; wr = 1'b0; wslot = '0; wval = '0;
    done = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset values
    chk(gv == 1'b0, "R12 grant_valid", int'(gv), 0);
    chk(rf == 1'b0, "R12 refill", int'(rf), 0);
    chk(early == 1'b0, "R12 early_close", int'(early), 0);
    chk(idle == '0, "R12 idle_cycles", int'(idle), 0);
    chk(stray == 1'b0, "R12 stray_done", int'(stray), 0);
    rst_n = 1'b1;

    // Empty budgets: early refills every cycle (R7), idle counting (R10)
    for (int c = 0; c < 8; c++) step(1, 0, 0, 0);

    // Load budgets into the shadow store (R9)
    write_cred(0, 2); write_cred(1, 1); write_cred(2, 0); write_cred(3, 3);

    // All ready, full completion speed: round-robin and exhaustion (R3 R4 R7)
    for (int c = 0; c < 60; c++) step(1, 100, 0, 0);

    // Random ready, slow completions, periodic ticks incl. during grants (R5 R6 R8)
    for (int c = 0; c < 600; c++) step(2, 30, (c % 47) == 0, 0);

    // Mid-period budget rewrite; takes effect only at next refill (R9)
    write_cred(2, 4); write_cred(0, 1);
    for (int c = 0; c < 300; c++) step(2, 40, (c % 83) == 0, 0);

    // Nothing ready: skipping and idle accounting (R5 R10)
    for (int c = 0; c < 100; c++) step(0, 0, (c % 50) == 0, 0);

    // Stray completion with no grant (R11)
    step(0, 0, 0, 1);
    for (int c = 0; c < 5; c++) step(0, 0, 0, 0);

    // Larger budgets and long random run
    write_cred(0, 7); write_cred(1, 5); write_cred(2, 9); write_cred(3, 2);
    for (int c = 0; c < 1500; c++) step(2, 25, (c % 131) == 0, (c % 397) == 5);

    @(negedge clk);
    compare_all();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule